// File: doc/BRIEF.md
# Mirrored Transmit Byte-Count Table Writer

This block maintains the per-queue byte-count tables that a transmit scheduler consults when it sizes a window of pending descriptors. A request names a queue, a descriptor slot and a frame length. The block turns that request into 16-bit table entries written through a simple memory write port into a table region that starts at a programmable base address. Each queue owns a 1024-byte table of 320 entries: 256 entries for the descriptor slots and 64 more that hold copies of slots 0 to 63. Because of these copies, a reader can walk any run of up to 64 consecutive entries linearly and never has to wrap.

A slot in the low 64 is written twice: first at its own position, then one cycle later at its position plus 256. The block stays busy across both writes. It also keeps a local shadow of all table contents. A read port takes a window start and an offset and returns both the linear entry number, which is never folded, and the byte count stored there.

Top module: `bct_writer`

## Requirements
- R1: After synchronous reset, busy and mem_we are low and req_ready is high.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both high. In the next cycle the block drives mem_we high with mem_addr = base_addr + req_queue*1024 + req_index*2.
- R3: If req_index is below 64, the cycle after the first write carries a second write with the same data at the first address plus 512, which is entry index+256.
- R4: If req_index is 64 or above, exactly one write is made, and mem_we is low in the cycle after it.
- R5: busy is high in every write cycle, and req_ready is its inverse. A request presented while busy is ignored: it causes no write and does not change the table contents.
- R6: mem_wdata bits 15:12 are always zero and bits 11:0 carry the byte count. A count above 4095 is written as 4095, and sat_flag is high only during the first write of such a request.
- R7: Read inputs (rd_queue, rd_start, rd_offset with an offset below 64) that are sampled on a rising edge give, after that edge, rd_entry = rd_start + rd_offset as a 9-bit value with no modulo. They also give rd_count = the last count written to that queue at slot (rd_start + rd_offset) mod 256.
- R8: A write to one queue does not change the entries read back for another queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_addr | input | 32 | Byte address of queue 0's table |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_queue | input | 4 | Queue number |
| req_index | input | 8 | Descriptor slot |
| req_bytes | input | 16 | Frame length in bytes |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 16 | Table entry to write |
| busy | output | 1 | Write sequence in progress |
| sat_flag | output | 1 | Count was clipped to 4095 |
| rd_queue | input | 4 | Read queue |
| rd_start | input | 8 | Read window start slot |
| rd_offset | input | 6 | Offset inside the window |
| rd_entry | output | 9 | Linear entry number read |
| rd_count | output | 12 | Byte count at that entry |

## Verification
The bench targets the boundary between mirrored and plain slots: slots 63 and 64, slot 0 and slot 255. A design with an off-by-one in the mirror test would either miss the copy of slot 63 or write a stray copy of slot 64. Counts of 4095, 4096, 5000 and 65535 test the clipping. A design that truncates instead of clipping would write 0 or 904 and would leave sat_flag low. A request pulsed while busy must leave no write and no table change, so a design that latches it would show an extra write. Window reads that cross 255 must report entry numbers such as 256 and 260 together with the count of the folded slot, which exposes a reader that folds the number or indexes the wrong slot.

// File: rtl/bct_pkg.sv
package bct_pkg;
    localparam int NUM_QUEUES  = 16;
    localparam int SLOTS       = 256;
    localparam int WINDOW      = 64;
    localparam int COUNT_W     = 12;
    localparam int ENTRY_W     = 16;
    localparam int RAW_W       = 16;
    localparam int ADDR_W      = 32;
    localparam int TABLE_BYTES = 1024;
    localparam int ENTRY_BYTES = ENTRY_W / 8;

    localparam int QUEUE_W  = $clog2(NUM_QUEUES);
    localparam int SLOT_W   = $clog2(SLOTS);
    localparam int OFFS_W   = $clog2(WINDOW);
    localparam int LINEAR_W = SLOT_W + 1;
    localparam int Q_SHIFT  = $clog2(TABLE_BYTES);
    localparam int E_SHIFT  = $clog2(ENTRY_BYTES);
    localparam int COUNT_MAX = (1 << COUNT_W) - 1;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FIRST = 2'd1,
        PH_COPY  = 2'd2
    } phase_e;

    typedef struct packed {
        logic [QUEUE_W-1:0] queue;
        logic [SLOT_W-1:0]  slot;
        logic [COUNT_W-1:0] count;
        logic               clipped;
    } job_t;

    function automatic logic [COUNT_W-1:0] clip_count(input logic [RAW_W-1:0] raw);
        if (raw > RAW_W'(COUNT_MAX))
            return COUNT_W'(COUNT_MAX);
        return raw[COUNT_W-1:0];
    endfunction

    function automatic logic needs_copy(input logic [SLOT_W-1:0] slot);
        return slot < SLOT_W'(WINDOW);
    endfunction
endpackage

// File: rtl/bct_seq.sv
module bct_seq
    import bct_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  job_t job_in,
    output job_t job_q,
    output phase_e phase
);
    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            job_q <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (take) begin
                        job_q <= job_in;
                        phase <= PH_FIRST;
                    end
                end
                PH_FIRST: phase <= needs_copy(job_q.slot) ? PH_COPY : PH_IDLE;
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    assert_copy_follows_first_R3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_COPY) |-> ($past(phase) == PH_FIRST));
    assert_take_only_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |=> !(phase == PH_FIRST && $past(phase) == PH_FIRST));
endmodule

// File: rtl/bct_addr.sv
module bct_addr
    import bct_pkg::*;
(
    input  logic [ADDR_W-1:0]  base,
    input  logic [QUEUE_W-1:0] queue,
    input  logic [SLOT_W-1:0]  slot,
    input  logic               upper,
    output logic [ADDR_W-1:0]  addr
);
    logic [LINEAR_W-1:0] linear;
    logic [ADDR_W-1:0]   q_off;
    logic [ADDR_W-1:0]   e_off;

    always_comb begin
        linear = {upper, slot};
        q_off  = ADDR_W'(queue) << Q_SHIFT;
        e_off  = ADDR_W'(linear) << E_SHIFT;
        addr   = base + q_off + e_off;
    end
endmodule

// File: rtl/bct_shadow.sv
module bct_shadow
    import bct_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [QUEUE_W-1:0]  wr_queue,
    input  logic [SLOT_W-1:0]   wr_slot,
    input  logic [COUNT_W-1:0]  wr_count,
    input  logic [QUEUE_W-1:0]  rd_queue,
    input  logic [SLOT_W-1:0]   rd_start,
    input  logic [OFFS_W-1:0]   rd_offset,
    output logic [LINEAR_W-1:0] rd_entry,
    output logic [COUNT_W-1:0]  rd_count
);
    localparam int WORDS = NUM_QUEUES * SLOTS;

    logic [COUNT_W-1:0] store [WORDS];
    logic [LINEAR_W-1:0] lin;
    logic [SLOT_W-1:0]   folded;

    always_comb begin
        lin    = LINEAR_W'(rd_start) + LINEAR_W'(rd_offset);
        folded = lin[SLOT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            store[{wr_queue, wr_slot}] <= wr_count;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_entry <= '0;
            rd_count <= '0;
        end else begin
            rd_entry <= lin;
            rd_count <= store[{rd_queue, folded}];
        end
    end

    assert_entry_in_table_R7: assert property (@(posedge clk) disable iff (rst)
        rd_entry <= LINEAR_W'(SLOTS + WINDOW - 2));
endmodule

// File: rtl/bct_writer.sv
module bct_writer
    import bct_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [QUEUE_W-1:0]  req_queue,
    input  logic [SLOT_W-1:0]   req_index,
    input  logic [RAW_W-1:0]    req_bytes,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [ENTRY_W-1:0]  mem_wdata,
    output logic                busy,
    output logic                sat_flag,
    input  logic [QUEUE_W-1:0]  rd_queue,
    input  logic [SLOT_W-1:0]   rd_start,
    input  logic [OFFS_W-1:0]   rd_offset,
    output logic [LINEAR_W-1:0] rd_entry,
    output logic [COUNT_W-1:0]  rd_count
);
    phase_e phase;
    job_t   job_in;
    job_t   job_q;
    logic   take;

    always_comb begin
        job_in.queue   = req_queue;
        job_in.slot    = req_index;
        job_in.count   = clip_count(req_bytes);
        job_in.clipped = req_bytes > RAW_W'(COUNT_MAX);
        busy      = (phase != PH_IDLE);
        req_ready = !busy;
        take      = req_valid && req_ready;
        mem_we    = busy;
        mem_wdata = {{(ENTRY_W-COUNT_W){1'b0}}, job_q.count};
        sat_flag  = (phase == PH_FIRST) && job_q.clipped;
    end

    bct_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .take   (take),
        .job_in (job_in),
        .job_q  (job_q),
        .phase  (phase)
    );

    bct_addr u_addr (
        .base  (base_addr),
        .queue (job_q.queue),
        .slot  (job_q.slot),
        .upper (phase == PH_COPY),
        .addr  (mem_addr)
    );

    bct_shadow u_shadow (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (take),
        .wr_queue  (req_queue),
        .wr_slot   (req_index),
        .wr_count  (job_in.count),
        .rd_queue  (rd_queue),
        .rd_start  (rd_start),
        .rd_offset (rd_offset),
        .rd_entry  (rd_entry),
        .rd_count  (rd_count)
    );

    assert_write_after_take_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> mem_we);
    assert_copy_offset_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(SLOTS * ENTRY_BYTES)
                                       && mem_wdata == $past(mem_wdata)));
    assert_at_most_two_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |=> !mem_we);
    assert_write_while_busy_R5: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (busy && !req_ready));
    assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_wdata[ENTRY_W-1:COUNT_W] == '0));
    assert_flag_first_only_R6: assert property (@(posedge clk) disable iff (rst)
        sat_flag |-> (mem_we && !$past(mem_we) && mem_wdata[COUNT_W-1:0] == COUNT_W'(COUNT_MAX)));
endmodule

// File: tb/sim_bct_writer.sv
module sim_bct_writer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] base_addr = 32'h0004_0000;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_queue = '0;
    logic [7:0]  req_index = '0;
    logic [15:0] req_bytes = '0;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        busy;
    logic        sat_flag;
    logic [3:0]  rd_queue = '0;
    logic [7:0]  rd_start = '0;
    logic [5:0]  rd_offset = '0;
    logic [8:0]  rd_entry;
    logic [11:0] rd_count;

    int checks = 0;
    int errors = 0;
    logic [11:0] model [16][256];

    always #10 clk = ~clk;

    bct_writer u0 (.*);

    localparam int NV = 8;
    localparam logic [27:0] VECS [NV] = '{
        {4'd0,  8'd0,   16'd100},
        {4'd0,  8'd63,  16'd4095},
        {4'd0,  8'd64,  16'd5},
        {4'd15, 8'd255, 16'd1500},
        {4'd3,  8'd10,  16'd5000},
        {4'd7,  8'd200, 16'd0},
        {4'd15, 8'd0,   16'd65535},
        {4'd1,  8'd128, 16'd4096}
    };

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] q, input logic [7:0] idx, input logic [15:0] b);
        logic [31:0] a;
        logic [11:0] c;
        bit clip;
        clip = b > 16'd4095;
        c = clip ? 12'd4095 : b[11:0];
        a = base_addr + 32'(q) * 32'd1024 + 32'(idx) * 32'd2;
        @(negedge clk);
        req_valid = 1'b1; req_queue = q; req_index = idx; req_bytes = b;
        @(negedge clk);
        req_valid = 1'b0;
        model[q][idx] = c;
        chk(mem_we === 1'b1, "R2 first we", longint'(mem_we), 1);
        chk(mem_addr === a, "R2 first addr", longint'(mem_addr), longint'(a));
        chk(mem_wdata === {4'h0, c}, "R6 data", longint'(mem_wdata), longint'({4'h0, c}));
        chk(sat_flag === clip, "R6 sat_flag", longint'(sat_flag), longint'(clip));
        chk(busy === 1'b1 && req_ready === 1'b0, "R5 busy", longint'(busy), 1);
        @(negedge clk);
        if (idx < 8'd64) begin
            chk(mem_we === 1'b1, "R3 copy we", longint'(mem_we), 1);
            chk(mem_addr === a + 32'd512, "R3 copy addr", longint'(mem_addr), longint'(a + 32'd512));
            chk(mem_wdata === {4'h0, c}, "R3 copy data", longint'(mem_wdata), longint'({4'h0, c}));
            chk(sat_flag === 1'b0, "R6 flag on copy", longint'(sat_flag), 0);
            @(negedge clk);
        end
        chk(mem_we === 1'b0 && busy === 1'b0, "R4 write count", longint'(mem_we), 0);
    endtask

    task automatic rd(input logic [3:0] q, input logic [7:0] s, input logic [5:0] k);
        logic [8:0] e;
        e = 9'(s) + 9'(k);
        @(negedge clk);
        rd_queue = q; rd_start = s; rd_offset = k;
        @(negedge clk);
        chk(rd_entry === e, "R7 entry", longint'(rd_entry), longint'(e));
        chk(rd_count === model[q][e[7:0]], "R7/R8 count", longint'(rd_count), longint'(model[q][e[7:0]]));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && mem_we === 1'b0 && req_ready === 1'b1, "R1 reset", longint'(busy), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && req_ready === 1'b1, "R1 after reset", longint'(req_ready), 1);

        for (int i = 0; i < NV; i++)
            issue(VECS[i][27:24], VECS[i][23:16], VECS[i][15:0]);

        issue(4'd2, 8'd4, 16'd777);
        // R5: request pulsed while busy is ignored
        @(negedge clk);
        req_valid = 1'b1; req_queue = 4'd2; req_index = 8'd70; req_bytes = 16'd900;
        @(negedge clk);
        req_queue = 4'd9; req_index = 8'd1; req_bytes = 16'd11;
        model[2][70] = 12'd900;
        chk(mem_we === 1'b1, "R5 first accepted", longint'(mem_we), 1);
        @(negedge clk);
        req_valid = 1'b0;
        chk(mem_we === 1'b0, "R5 ignored no write", longint'(mem_we), 0);
        @(negedge clk);
        chk(mem_we === 1'b0, "R5 ignored idle", longint'(mem_we), 0);
        model[9][1] = 12'd0;
        issue(4'd9, 8'd1, 16'd0);
        issue(4'd9, 8'd2, 16'd33);

        rd(4'd2, 8'd250, 6'd10);
        rd(4'd0, 8'd0, 6'd63);
        rd(4'd15, 8'd255, 6'd1);
        rd(4'd0, 8'd200, 6'd56);
        rd(4'd1, 8'd100, 6'd28);
        rd(4'd2, 8'd30, 6'd40);
        rd(4'd9, 8'd2, 6'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R5 watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule